// File: doc/BRIEF.md
# Load-Store Queue Allocation Tracker

This block keeps program-order bookkeeping for the memory operations in flight in an out-of-order core. It has two circular rings, one for loads and one for stores. Each entry holds a 16-bit sequence number and a valid flag. When an entry is allocated, the block also records where the other ring's tail stands, so later ordering checks know which older operations of the other kind exist. Addresses, data and cache traffic are handled elsewhere.

The pipeline offers one allocation per cycle and reads back the slot index and the cross-ring tag. A commit input gives the youngest committed sequence number. Loads up to that number leave the head, and stores up to it are released for writeback. A separate completion input retires the released store at the head. A squash input gives the oldest surviving sequence number. Younger entries are removed from the tail, except that the store walk halts at a store that is already released. The block also reports the number of operations of either kind that can still be accepted.

Top module: `lsqat_tracker`

## Requirements
- R1: The load ring holds at most LD_CAP entries and the store ring at most ST_CAP entries. Each ring has LD_CAP+1 or ST_CAP+1 slots. While the addressed ring is full, `insReady` is 0 and an offered insert changes nothing.
- R2: An accepted load takes the current store tail as its tag on `insPeerIdx`. If the store ring is empty, it takes `insPeerNone`=1 instead. The tag is kept with the entry and appears on `ldHeadPeer`/`ldHeadNone` when the entry reaches the head.
- R3: An accepted store takes the current load tail as its tag (`insPeerNone`=0). The tag is kept with the entry and appears on `stHeadPeer`.
- R4: `freeSlots` equals min(LD_CAP-ldCount, ST_CAP-stCount).
- R5: On commit, loads leave the head in order for as long as the ring is not empty and the head sequence number is at or below `commitSeq`. The walk stops at the first larger sequence number.
- R6: On squash, loads are removed backward from the tail while their sequence number is greater than `squashSeq`. The next load is then allocated in the slot that the oldest removed load held.
- R7: Store squash works the same way, but it stops at the first store already released for writeback (`stHeadWb`=1 marks a released head), so such a store and all older stores survive.
- R8: Commit releases stores from the head whose sequence number is at or below `commitSeq`. `stDoneValid` pops the head store only when it is released. On an unreleased head or an empty ring it has no effect. A load never shows as released.
- R9: A slot index advances from the last slot (LD_CAP or ST_CAP) to 0. A tail moved back by a squash steps from 0 to the last slot.
- R10: When squash and commit arrive in the same cycle, the squash is applied first, so a store removed by the squash cannot be released by that commit. Any insert offered during a squash is refused (`insReady`=0).
- R11: After reset both rings are empty and `freeSlots` equals min(LD_CAP, ST_CAP).
- R12: Sequence numbers are compared as plain unsigned values, with no wraparound handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert offered this cycle |
| insIsStore | input | 1 | 1 = insert a store, 0 = insert a load |
| insSeq | input | SEQ_W | Sequence number of the inserted operation |
| insReady | output | 1 | Offered insert is accepted this cycle |
| insOwnIdx | output | IW | Slot the insert takes in its own ring |
| insPeerIdx | output | IW | Tail position of the other ring (the tag) |
| insPeerNone | output | 1 | Load tag is "none" because the store ring is empty |
| commitValid | input | 1 | Commit this cycle |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| stDoneValid | input | 1 | Retire the head store if released |
| squashValid | input | 1 | Squash this cycle |
| squashSeq | input | SEQ_W | Sequence numbers above this are squashed |
| ldCount | output | IW | Loads held |
| stCount | output | IW | Stores held |
| freeSlots | output | IW | Inserts of either kind still possible |
| ldHeadSeq | output | SEQ_W | Sequence number of the head load |
| ldHeadPeer | output | IW | Store-tail tag of the head load |
| ldHeadNone | output | 1 | Head load was tagged "none" |
| stHeadSeq | output | SEQ_W | Sequence number of the head store |
| stHeadPeer | output | IW | Load-tail tag of the head store |
| stHeadWb | output | 1 | Head store is released for writeback |

## Verification
Inserts alternate between kinds so that each tag reads a tail the other ring has just moved, and one load goes in with an empty store ring to cover the "none" case. Commits use a bound that falls between two queued loads, which shows that the pop stops at the first larger number rather than draining the ring. Squashes run once with only loads and once with a released store in the path. The second case separates a walk that respects the release mark from one that does not. A cycle that carries squash, commit and an insert together separates squash-first from commit-first order through the surviving store count. Runs that fill a ring and wrap the tail past the last slot check the full refusal and the wrap.

// File: rtl/lsqat_pkg.sv
package lsqat_pkg;

  // Per-ring strobes from control to a ring datapath.
  typedef struct packed {
    logic ins;     // allocate at tail
    logic squash;  // remove younger entries from tail
    logic commit;  // load: pop head run; store: release head run
    logic retire;  // store only: pop a released head
  } ringCmd_t;

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lsqat_ring.sv
module lsqat_ring
  import lsqat_pkg::*;
#(
  parameter int unsigned SLOTS    = 5,
  parameter int unsigned IW       = 3,
  parameter int unsigned SEQ_W    = 16,
  parameter int unsigned TAG_W    = 4,
  parameter bit          IS_STORE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringCmd_t         cmd,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic [TAG_W-1:0] insTag,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [SEQ_W-1:0] commitSeq,
  output logic [IW-1:0]    tailIdx,
  output logic [IW-1:0]    countOut,
  output logic             full,
  output logic [SEQ_W-1:0] headSeq,
  output logic [TAG_W-1:0] headTag,
  output logic             headWb
);

  localparam logic [IW-1:0] LAST_CNT = IW'(SLOTS - 1);

  logic [SEQ_W-1:0] seqMem [SLOTS];
  logic [TAG_W-1:0] tagMem [SLOTS];
  logic [SLOTS-1:0] vldMem;
  logic [SLOTS-1:0] wbMem;
  logic [IW-1:0]    head, tail, count;

  logic [IW-1:0]    nRm, live, nPop;
  logic [SLOTS-1:0] rmVec, popVec, markVec;

  function automatic logic [IW-1:0] stepIdx(logic [IW-1:0] base, int delta);
    int sum;
    sum = (int'(base) + delta + 2 * int'(SLOTS)) % int'(SLOTS);
    return IW'(sum);
  endfunction

  // Backward squash walk from the tail.
  always_comb begin
    logic          go;
    logic [IW-1:0] idx;
    nRm   = '0;
    rmVec = '0;
    go    = cmd.squash;
    for (int k = 0; k < int'(SLOTS) - 1; k++) begin
      idx = stepIdx(tail, -1 - k);
      if (go && (k < int'(count)) && (seqMem[idx] > squashSeq) &&
          !(IS_STORE && wbMem[idx])) begin
        nRm        = nRm + IW'(1);
        rmVec[idx] = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end

  assign live = count - nRm;

  generate
    if (!IS_STORE) begin : g_load
      // Loads: pop the committed run from the head.
      always_comb begin
        logic          go;
        logic [IW-1:0] idx;
        nPop    = '0;
        popVec  = '0;
        markVec = '0;
        go      = cmd.commit;
        for (int k = 0; k < int'(SLOTS) - 1; k++) begin
          idx = stepIdx(head, k);
          if (go && (k < int'(live)) && (seqMem[idx] <= commitSeq)) begin
            nPop        = nPop + IW'(1);
            popVec[idx] = 1'b1;
          end else begin
            go = 1'b0;
          end
        end
      end
    end else begin : g_store
      // Stores: release the committed run, retire a released head.
      always_comb begin
        logic          go;
        logic [IW-1:0] idx;
        nPop    = '0;
        popVec  = '0;
        markVec = '0;
        go      = cmd.commit;
        for (int k = 0; k < int'(SLOTS) - 1; k++) begin
          idx = stepIdx(head, k);
          if (go && (k < int'(live)) && (seqMem[idx] <= commitSeq)) begin
            markVec[idx] = 1'b1;
          end else begin
            go = 1'b0;
          end
        end
        if (cmd.retire && (count != '0) && wbMem[head]) begin
          nPop         = IW'(1);
          popVec[head] = 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      vldMem <= '0;
      wbMem  <= '0;
    end else begin
      head  <= stepIdx(head, int'(nPop));
      tail  <= cmd.ins ? stepIdx(tail, 1) : stepIdx(tail, -int'(nRm));
      count <= live - nPop + {{(IW-1){1'b0}}, cmd.ins};
      for (int i = 0; i < int'(SLOTS); i++) begin
        if (rmVec[i] || popVec[i]) begin
          vldMem[i] <= 1'b0;
          wbMem[i]  <= 1'b0;
        end else if (markVec[i]) begin
          wbMem[i] <= 1'b1;
        end
      end
      if (cmd.ins) begin
        seqMem[tail] <= insSeq;
        tagMem[tail] <= insTag;
        vldMem[tail] <= 1'b1;
        wbMem[tail]  <= 1'b0;
      end
    end
  end

  assign tailIdx  = tail;
  assign countOut = count;
  assign full     = (count == LAST_CNT);
  assign headSeq  = seqMem[head];
  assign headTag  = tagMem[head];
  assign headWb   = wbMem[head] && (count != '0);

  // R1: occupancy never exceeds usable capacity
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= LAST_CNT);
  // R1: an occupied head slot carries a set valid flag
  a_r1_head_valid: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> vldMem[head]);
  // R10: control never allocates during a squash
  a_r10_no_ins_squash: assert property (@(posedge clk) disable iff (!rstN)
    cmd.squash |-> !cmd.ins);
  // R6: a squash never grows the ring
  a_r6_squash_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.squash && !cmd.ins) |=> (count <= $past(count)));

  generate
    if (!IS_STORE) begin : g_ld_chk
      // R5: a head younger than the commit bound stays put
      a_r5_head_holds: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.commit && (count != '0) && (seqMem[head] > commitSeq))
        |=> ($stable(head)));
      // R8: loads are never retired through the store path
      a_r8_no_ld_retire: assert property (@(posedge clk) disable iff (!rstN)
        !cmd.retire);
    end else begin : g_st_chk
      // R7: a released head store survives a squash
      a_r7_released_kept: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.squash && !cmd.retire && (count != '0) && wbMem[head])
        |=> (count != '0));
    end
  endgenerate

endmodule

// File: rtl/lsqat_ctrl.sv
module lsqat_ctrl
  import lsqat_pkg::*;
#(
  parameter int unsigned LD_CAP = 4,
  parameter int unsigned ST_CAP = 4,
  parameter int unsigned IW     = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          insValid,
  input  logic          insIsStore,
  input  logic          commitValid,
  input  logic          stDoneValid,
  input  logic          squashValid,
  input  logic          ldFull,
  input  logic          stFull,
  input  logic [IW-1:0] ldCount,
  input  logic [IW-1:0] stCount,
  input  logic [IW-1:0] ldTail,
  input  logic [IW-1:0] stTail,
  output ringCmd_t      ldCmd,
  output ringCmd_t      stCmd,
  output logic          insReady,
  output logic [IW-1:0] insOwnIdx,
  output logic [IW-1:0] insPeerIdx,
  output logic          insPeerNone,
  output logic [IW:0]   ldTag,
  output logic [IW-1:0] stTag,
  output logic [IW-1:0] freeSlots
);

  logic          stEmpty;
  logic [IW-1:0] ldFree, stFree;

  assign stEmpty = (stCount == '0);
  assign insReady = !squashValid && (insIsStore ? !stFull : !ldFull);

  always_comb begin
    ldCmd        = '0;
    stCmd        = '0;
    ldCmd.ins    = insValid && insReady && !insIsStore;
    stCmd.ins    = insValid && insReady && insIsStore;
    ldCmd.squash = squashValid;
    stCmd.squash = squashValid;
    ldCmd.commit = commitValid;
    stCmd.commit = commitValid;
    stCmd.retire = stDoneValid;
  end

  assign ldTag       = {stEmpty, stEmpty ? {IW{1'b0}} : stTail};
  assign stTag       = ldTail;
  assign insOwnIdx   = insIsStore ? stTail : ldTail;
  assign insPeerIdx  = insIsStore ? ldTail : (stEmpty ? '0 : stTail);
  assign insPeerNone = !insIsStore && stEmpty;

  assign ldFree    = IW'(LD_CAP) - ldCount;
  assign stFree    = IW'(ST_CAP) - stCount;
  assign freeSlots = (ldFree < stFree) ? ldFree : stFree;

  // R10: nothing is accepted while a squash is in progress
  a_r10_squash_refuses: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> !insReady);
  // R1: a full load ring refuses a load insert
  a_r1_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insIsStore && (ldCount == IW'(LD_CAP))) |-> !insReady);
  // R4: free count never exceeds either ring's room
  a_r4_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    (freeSlots <= IW'(LD_CAP) - ldCount) && (freeSlots <= IW'(ST_CAP) - stCount));

endmodule

// File: rtl/lsqat_tracker.sv
module lsqat_tracker
  import lsqat_pkg::*;
#(
  parameter int unsigned LD_CAP = 4,
  parameter int unsigned ST_CAP = 4,
  parameter int unsigned SEQ_W  = 16,
  localparam int unsigned IW    = $clog2(maxOf(LD_CAP, ST_CAP) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             insIsStore,
  input  logic [SEQ_W-1:0] insSeq,
  output logic             insReady,
  output logic [IW-1:0]    insOwnIdx,
  output logic [IW-1:0]    insPeerIdx,
  output logic             insPeerNone,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             stDoneValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  output logic [IW-1:0]    ldCount,
  output logic [IW-1:0]    stCount,
  output logic [IW-1:0]    freeSlots,
  output logic [SEQ_W-1:0] ldHeadSeq,
  output logic [IW-1:0]    ldHeadPeer,
  output logic             ldHeadNone,
  output logic [SEQ_W-1:0] stHeadSeq,
  output logic [IW-1:0]    stHeadPeer,
  output logic             stHeadWb
);

  ringCmd_t      ldCmd, stCmd;
  logic          ldFull, stFull, ldHeadWb;
  logic [IW-1:0] ldTail, stTail, stTag;
  logic [IW:0]   ldTag, ldHeadTag;

  lsqat_ctrl #(.LD_CAP(LD_CAP), .ST_CAP(ST_CAP), .IW(IW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insIsStore(insIsStore),
    .commitValid(commitValid), .stDoneValid(stDoneValid),
    .squashValid(squashValid),
    .ldFull(ldFull), .stFull(stFull),
    .ldCount(ldCount), .stCount(stCount),
    .ldTail(ldTail), .stTail(stTail),
    .ldCmd(ldCmd), .stCmd(stCmd),
    .insReady(insReady), .insOwnIdx(insOwnIdx),
    .insPeerIdx(insPeerIdx), .insPeerNone(insPeerNone),
    .ldTag(ldTag), .stTag(stTag), .freeSlots(freeSlots)
  );

  lsqat_ring #(.SLOTS(LD_CAP + 1), .IW(IW), .SEQ_W(SEQ_W), .TAG_W(IW + 1),
               .IS_STORE(1'b0)) ldRing_i (
    .clk(clk), .rstN(rstN), .cmd(ldCmd),
    .insSeq(insSeq), .insTag(ldTag),
    .squashSeq(squashSeq), .commitSeq(commitSeq),
    .tailIdx(ldTail), .countOut(ldCount), .full(ldFull),
    .headSeq(ldHeadSeq), .headTag(ldHeadTag), .headWb(ldHeadWb)
  );

  lsqat_ring #(.SLOTS(ST_CAP + 1), .IW(IW), .SEQ_W(SEQ_W), .TAG_W(IW),
               .IS_STORE(1'b1)) stRing_i (
    .clk(clk), .rstN(rstN), .cmd(stCmd),
    .insSeq(insSeq), .insTag(stTag),
    .squashSeq(squashSeq), .commitSeq(commitSeq),
    .tailIdx(stTail), .countOut(stCount), .full(stFull),
    .headSeq(stHeadSeq), .headTag(stHeadPeer), .headWb(stHeadWb)
  );

  assign ldHeadPeer = ldHeadTag[IW-1:0];
  assign ldHeadNone = ldHeadTag[IW];

  // R8: loads are never marked released for writeback
  a_r8_load_not_released: assert property (@(posedge clk) disable iff (!rstN)
    !ldHeadWb);

endmodule

// File: tb/lsqat_tracker_tb_top.sv
module lsqat_tracker_tb_top;

  localparam int unsigned SEQ_W = 16;
  localparam int unsigned IW    = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             insValid, insIsStore;
  logic [SEQ_W-1:0] insSeq;
  logic             insReady;
  logic [IW-1:0]    insOwnIdx, insPeerIdx;
  logic             insPeerNone;
  logic             commitValid;
  logic [SEQ_W-1:0] commitSeq;
  logic             stDoneValid, squashValid;
  logic [SEQ_W-1:0] squashSeq;
  logic [IW-1:0]    ldCount, stCount, freeSlots;
  logic [SEQ_W-1:0] ldHeadSeq, stHeadSeq;
  logic [IW-1:0]    ldHeadPeer, stHeadPeer;
  logic             ldHeadNone, stHeadWb;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsqat_tracker dut_i (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insIsStore(insIsStore), .insSeq(insSeq),
    .insReady(insReady), .insOwnIdx(insOwnIdx), .insPeerIdx(insPeerIdx),
    .insPeerNone(insPeerNone),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .stDoneValid(stDoneValid), .squashValid(squashValid), .squashSeq(squashSeq),
    .ldCount(ldCount), .stCount(stCount), .freeSlots(freeSlots),
    .ldHeadSeq(ldHeadSeq), .ldHeadPeer(ldHeadPeer), .ldHeadNone(ldHeadNone),
    .stHeadSeq(stHeadSeq), .stHeadPeer(stHeadPeer), .stHeadWb(stHeadWb)
  );

  task automatic check(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle();
    insValid = 1'b0; insIsStore = 1'b0; insSeq = '0;
    commitValid = 1'b0; commitSeq = '0;
    stDoneValid = 1'b0; squashValid = 1'b0; squashSeq = '0;
  endtask

  // Inputs held across one rising edge; returns at the following falling edge.
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic insOp(bit st, int seq, int expOwn, int expPeer, bit expNone, string tag);
    insValid = 1'b1; insIsStore = st; insSeq = SEQ_W'(seq);
    #1;
    check({tag, " insReady"}, int'(insReady), 1);
    check({tag, " own index"}, int'(insOwnIdx), expOwn);
    check({tag, " none flag"}, int'(insPeerNone), int'(expNone));
    if (!expNone) check({tag, " peer index"}, int'(insPeerIdx), expPeer);
    tick();
  endtask

  task automatic commitOp(int seq);
    commitValid = 1'b1; commitSeq = SEQ_W'(seq);
    tick();
  endtask

  task automatic squashOp(int seq);
    squashValid = 1'b1; squashSeq = SEQ_W'(seq);
    tick();
  endtask

  task automatic doneOp();
    stDoneValid = 1'b1;
    tick();
  endtask

  task automatic testReset();
    check("R11 ldCount", int'(ldCount), 0);
    check("R11 stCount", int'(stCount), 0);
    check("R11 freeSlots", int'(freeSlots), 4);
    check("R11 stHeadWb", int'(stHeadWb), 0);
  endtask

  task automatic testTags();
    insOp(1'b0, 10, 0, 0, 1'b1, "R2 load into empty store ring");
    insOp(1'b1, 11, 0, 1, 1'b0, "R3 store tag");
    insOp(1'b0, 12, 1, 1, 1'b0, "R2 load tag");
    check("R4 freeSlots", int'(freeSlots), 2);
    check("R2 ldHeadSeq", int'(ldHeadSeq), 10);
    check("R2 ldHeadNone", int'(ldHeadNone), 1);
    check("R3 stHeadPeer", int'(stHeadPeer), 1);
    check("R3 stHeadSeq", int'(stHeadSeq), 11);
  endtask

  task automatic testCommit();
    commitOp(11);
    check("R5 ldCount after commit", int'(ldCount), 1);
    check("R5 ldHeadSeq", int'(ldHeadSeq), 12);
    check("R2 stored peer", int'(ldHeadPeer), 1);
    check("R2 stored none", int'(ldHeadNone), 0);
    check("R8 store released", int'(stHeadWb), 1);
    doneOp();
    check("R8 released store retired", int'(stCount), 0);
  endtask

  task automatic testFullWrap();
    insOp(1'b0, 20, 2, 0, 1'b1, "R9 load 20");
    insOp(1'b0, 21, 3, 0, 1'b1, "R9 load 21");
    insOp(1'b0, 22, 4, 0, 1'b1, "R9 load 22");
    check("R1 ldCount full", int'(ldCount), 4);
    check("R4 freeSlots zero", int'(freeSlots), 0);
    insValid = 1'b1; insIsStore = 1'b0; insSeq = SEQ_W'(99);
    #1;
    check("R1 insReady when full", int'(insReady), 0);
    tick();
    check("R1 ldCount after refused insert", int'(ldCount), 4);
    check("R1 ldHeadSeq after refused insert", int'(ldHeadSeq), 12);
    commitOp(20);
    check("R5 ldCount partial pop", int'(ldCount), 2);
    check("R5 ldHeadSeq partial pop", int'(ldHeadSeq), 21);
    insOp(1'b0, 23, 0, 0, 1'b1, "R9 wrap to slot 0");
    check("R9 ldCount", int'(ldCount), 3);
  endtask

  task automatic testLoadSquash();
    squashOp(21);
    check("R6 ldCount after squash", int'(ldCount), 1);
    check("R6 ldHeadSeq", int'(ldHeadSeq), 21);
    insOp(1'b0, 30, 4, 0, 1'b1, "R6 R9 tail back across 0");
  endtask

  task automatic testStoreSquash();
    insOp(1'b1, 40, 1, 0, 1'b0, "R3 store 40");
    insOp(1'b1, 41, 2, 0, 1'b0, "R3 store 41");
    insOp(1'b1, 42, 3, 0, 1'b0, "R3 store 42");
    check("R4 freeSlots store-limited", int'(freeSlots), 1);
    commitOp(40);
    check("R5 loads drained", int'(ldCount), 0);
    check("R8 head store released", int'(stHeadWb), 1);
    check("R8 stores kept", int'(stCount), 3);
    squashOp(39);
    check("R7 squash stops at released store", int'(stCount), 1);
    check("R7 survivor seq", int'(stHeadSeq), 40);
    insOp(1'b1, 50, 2, 0, 1'b0, "R7 store tail moved back");
  endtask

  task automatic testOrdering();
    insOp(1'b0, 60, 0, 3, 1'b0, "R2 load 60");
    insOp(1'b0, 61, 1, 3, 1'b0, "R2 load 61");
    insOp(1'b0, 62, 2, 3, 1'b0, "R2 load 62");
    squashValid = 1'b1; squashSeq = SEQ_W'(45);
    commitValid = 1'b1; commitSeq = SEQ_W'(55);
    insValid = 1'b1; insIsStore = 1'b0; insSeq = SEQ_W'(63);
    #1;
    check("R10 insReady during squash", int'(insReady), 0);
    tick();
    check("R10 squash before commit stCount", int'(stCount), 1);
    check("R10 ldCount", int'(ldCount), 0);
    check("R10 stHeadSeq", int'(stHeadSeq), 40);
    doneOp();
    check("R8 retire released", int'(stCount), 0);
    doneOp();
    check("R8 retire on empty ignored", int'(stCount), 0);
    insOp(1'b1, 70, 2, 0, 1'b0, "R3 store 70");
    doneOp();
    check("R8 unreleased head kept", int'(stCount), 1);
    check("R8 unreleased head flag", int'(stHeadWb), 0);
    check("R12 head seq", int'(stHeadSeq), 70);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTags();
    testCommit();
    testFullWrap();
    testLoadSquash();
    testStoreSquash();
    testOrdering();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule